// File: doc/BRIEF.md
# Interrupt Vector Arbiter with Clear Return

This block sits between the register file of an interrupt controller and its bus read path. It sees the full set of source vectors: which sources are pending, which are enabled, and which are routed to the fast line. It also sees a 4-bit priority per source. When the register block asks for a vector word, the arbiter answers with one of two kinds of word. The normal vector word holds the winning source index and its priority. The fast vector word holds the winning source index alone. If nothing qualifies, the answer is all ones.

A request is a one-cycle strobe carrying the kind of word wanted. The response arrives a fixed number of cycles later. When a winner exists, a clear strobe carrying the winner's index goes out in the same cycle as the response, so the register block can retire that pending bit. Normal arbitration runs through a balanced comparison tree, which keeps the logic depth logarithmic in the source count. An optional register stage after the arbitration logic shortens the critical path at the cost of one cycle of latency.

Top module: `rsv_vector_resolver`

## Requirements
- R1: The priority of source n is read from bits [4n+3:4n] of the flat priority bus. This is the same as bits 4*(n mod 8) and up of 32-bit word n/8, with word w occupying bus bits [32w+31:32w].
- R2: A source is a normal candidate when it is pending, enabled, and not typed fast. The normal candidate with the largest priority value wins. Priority 0 is a valid candidate.
- R3: When several normal candidates share the largest priority, the one with the highest source index wins.
- R4: When a normal winner exists, the normal word is {10'b0, index[5:0], 12'b0, priority[3:0]}. That is, the index starts at bit 16 and the priority sits in bits 3:0.
- R5: A normal read with no normal candidate returns 32'hFFFFFFFF and produces no clear strobe.
- R6: A source is a fast candidate when it is pending, enabled, and typed fast. The lowest-numbered fast candidate wins, whatever its priority. The fast word is that index, zero-extended, in bits 5:0.
- R7: A fast read with no fast candidate returns 32'hFFFFFFFF and produces no clear strobe.
- R8: When a read finds a winner, the clear strobe is high for exactly the response cycle and carries the winner's index.
- R9: Each request strobe yields exactly one response strobe, 1+PIPE clock cycles later. No response appears without a request.
- R10: While reset is asserted, the response and clear strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_pend | input | 64 | Pending flag per source |
| src_en | input | 64 | Enable flag per source |
| src_fast | input | 64 | 1 = source routed to the fast line |
| src_pri | input | 256 | Packed 4-bit priorities, source n at [4n+3:4n] |
| req_vld | input | 1 | One-cycle read request strobe |
| req_fast | input | 1 | 1 = fast vector word requested, 0 = normal |
| rsp_vld | output | 1 | Response strobe |
| rsp_word | output | 32 | Vector word returned to the bus |
| clr_vld | output | 1 | Clear strobe for the winning pending bit |
| clr_idx | output | 6 | Index of the source to clear |

## Verification
The assertions assume three things about the inputs. The register block holds at most one request outstanding. It raises no request during the reset synchronizer's release cycles. It keeps `req_fast` meaningful only alongside `req_vld`, since the checker recovers the response kind from the request delayed by the pipeline depth. The stimulus issues a request only after the previous response has been seen. It also holds the source vectors steady across that window and waits out the reset release before the first read.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int unsigned RSV_WORDW = 32;
  localparam int unsigned RSV_IDX_LSB = 16;

  typedef enum logic {
    RSV_NORMAL = 1'b0,
    RSV_FAST   = 1'b1
  } rsv_kind_e;
endpackage

// File: rtl/rsv_norm_tree.sv
module rsv_norm_tree #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PRIW = 4,
  parameter int unsigned IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]      cand,
  input  logic [NSRC*PRIW-1:0] pri_flat,
  output logic                 win_any,
  output logic [IDXW-1:0]      win_idx,
  output logic [PRIW-1:0]      win_pri
);
  localparam int unsigned LEAVES = 1 << $clog2(NSRC);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic            nv [NODES];
  logic [IDXW-1:0] ni [NODES];
  logic [PRIW-1:0] np [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NSRC) begin : g_real
      assign nv[LEAVES-1+k] = cand[k];
      assign ni[LEAVES-1+k] = IDXW'(k);
      assign np[LEAVES-1+k] = pri_flat[k*PRIW +: PRIW];
    end else begin : g_pad
      assign nv[LEAVES-1+k] = 1'b0;
      assign ni[LEAVES-1+k] = '0;
      assign np[LEAVES-1+k] = '0;
    end
  end

  // Right child covers higher indices; equal priority prefers it.
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_r;
    assign take_r = nv[2*n+2] && (!nv[2*n+1] || (np[2*n+2] >= np[2*n+1]));
    assign nv[n]  = nv[2*n+1] | nv[2*n+2];
    assign ni[n]  = take_r ? ni[2*n+2] : ni[2*n+1];
    assign np[n]  = take_r ? np[2*n+2] : np[2*n+1];
  end

  assign win_any = nv[0];
  assign win_idx = ni[0];
  assign win_pri = np[0];
endmodule

// File: rtl/rsv_fast_pick.sv
module rsv_fast_pick #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic            win_any,
  output logic [IDXW-1:0] win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) win_idx = IDXW'(i);
    end
  end

  assign win_any = |cand;
endmodule

// File: rtl/rsv_vector_resolver.sv
module rsv_vector_resolver
  import rsv_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PRIW = 4,
  parameter int unsigned PIPE = 1,
  parameter int unsigned IDXW = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_pend,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC-1:0]      src_fast,
  input  logic [NSRC*PRIW-1:0] src_pri,
  input  logic                 req_vld,
  input  logic                 req_fast,
  output logic                 rsp_vld,
  output logic [RSV_WORDW-1:0] rsp_word,
  output logic                 clr_vld,
  output logic [IDXW-1:0]      clr_idx
);
  // reset synchronizer: assert async, release on clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // candidates
  logic [NSRC-1:0] cand_n, cand_f;
  assign cand_n = src_pend & src_en & ~src_fast;
  assign cand_f = src_pend & src_en &  src_fast;

  logic            n_any, f_any;
  logic [IDXW-1:0] n_idx, f_idx;
  logic [PRIW-1:0] n_pri;

  rsv_norm_tree #(.NSRC(NSRC), .PRIW(PRIW), .IDXW(IDXW)) u_tree (
    .cand(cand_n), .pri_flat(src_pri),
    .win_any(n_any), .win_idx(n_idx), .win_pri(n_pri)
  );

  rsv_fast_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_fast (
    .cand(cand_f), .win_any(f_any), .win_idx(f_idx)
  );

  // arbitration result bundle, optionally registered
  logic            a_vld, a_n_any, a_f_any;
  rsv_kind_e       a_kind;
  logic [IDXW-1:0] a_n_idx, a_f_idx;
  logic [PRIW-1:0] a_n_pri;

  if (PIPE != 0) begin : g_pipe
    logic            s_vld_q, s_n_any_q, s_f_any_q;
    rsv_kind_e       s_kind_q;
    logic [IDXW-1:0] s_n_idx_q, s_f_idx_q;
    logic [PRIW-1:0] s_n_pri_q;

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) s_vld_q <= 1'b0;
      else          s_vld_q <= req_vld;
    end

    always_ff @(posedge clk) begin
      if (req_vld) begin
        s_kind_q  <= rsv_kind_e'(req_fast);
        s_n_any_q <= n_any;
        s_n_idx_q <= n_idx;
        s_n_pri_q <= n_pri;
        s_f_any_q <= f_any;
        s_f_idx_q <= f_idx;
      end
    end

    assign a_vld   = s_vld_q;
    assign a_kind  = s_kind_q;
    assign a_n_any = s_n_any_q;
    assign a_n_idx = s_n_idx_q;
    assign a_n_pri = s_n_pri_q;
    assign a_f_any = s_f_any_q;
    assign a_f_idx = s_f_idx_q;
  end else begin : g_flat
    assign a_vld   = req_vld & rst_q_n;
    assign a_kind  = rsv_kind_e'(req_fast);
    assign a_n_any = n_any;
    assign a_n_idx = n_idx;
    assign a_n_pri = n_pri;
    assign a_f_any = f_any;
    assign a_f_idx = f_idx;
  end

  // output stage: next state
  logic                 hit_d;
  logic [RSV_WORDW-1:0] word_d;
  logic [IDXW-1:0]      idx_d;

  always_comb begin
    if (a_kind == RSV_FAST) begin
      hit_d  = a_f_any;
      idx_d  = a_f_idx;
      word_d = a_f_any ? RSV_WORDW'(a_f_idx) : '1;
    end else begin
      hit_d  = a_n_any;
      idx_d  = a_n_idx;
      word_d = a_n_any ? ((RSV_WORDW'(a_n_idx) << RSV_IDX_LSB) | RSV_WORDW'(a_n_pri))
                       : '1;
    end
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld <= 1'b0;
      clr_vld <= 1'b0;
    end else begin
      rsp_vld <= a_vld;
      clr_vld <= a_vld & hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (a_vld) begin
      rsp_word <= word_d;
      clr_idx  <= idx_d;
    end
  end
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int unsigned PIPE = 1,
  parameter int unsigned IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic            req_fast,
  input logic            rsp_vld,
  input logic [31:0]     rsp_word,
  input logic            clr_vld,
  input logic [IDXW-1:0] clr_idx
);
  localparam int unsigned LAT = 1 + PIPE;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!rsp_vld && !clr_vld)); // R10

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(req_vld, LAT)); // R9

  AST_CLR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |-> rsp_vld); // R8

  AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !clr_vld) |-> (rsp_word == 32'hFFFF_FFFF)); // R5

  AST_NORM_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !$past(req_fast, LAT)) |-> (rsp_word[16 +: IDXW] == clr_idx)); // R4

  AST_FAST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && $past(req_fast, LAT)) |-> (rsp_word == 32'(clr_idx))); // R6
endmodule

bind rsv_vector_resolver rsv_checker #(.PIPE(PIPE), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_fast(req_fast),
  .rsp_vld(rsp_vld), .rsp_word(rsp_word), .clr_vld(clr_vld), .clr_idx(clr_idx)
);

// File: tb/sim_rsv_vector_resolver.sv
`timescale 1ns/1ps
module sim_rsv_vector_resolver;
  localparam int PIPE = 1;
  localparam int LAT  = 1 + PIPE;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [63:0]  src_pend, src_en, src_fast;
  logic [255:0] src_pri;
  logic         req_vld, req_fast;
  logic         rsp_vld, clr_vld;
  logic [31:0]  rsp_word;
  logic [5:0]   clr_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rsv_vector_resolver #(.PIPE(PIPE)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .src_fast(src_fast), .src_pri(src_pri), .req_vld(req_vld),
    .req_fast(req_fast), .rsp_vld(rsp_vld), .rsp_word(rsp_word),
    .clr_vld(clr_vld), .clr_idx(clr_idx)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        clr;
    logic [5:0]  idx;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic set_pri(input int n, input logic [3:0] v);
    src_pri[4*n +: 4] = v;
  endtask

  task automatic clear_src();
    src_pend = '0; src_en = '0; src_fast = '0; src_pri = '0;
  endtask

  // independent model and driver
  task automatic do_read(input bit fast, input string tag);
    exp_t e;
    int   best, cnt;
    logic [63:0] c;
    e.word = 32'hFFFF_FFFF; e.clr = 1'b0; e.idx = '0;
    if (fast) begin
      c = src_pend & src_en & src_fast;
      for (int i = 63; i >= 0; i--)
        if (c[i]) begin e.word = 32'(i); e.clr = 1'b1; e.idx = 6'(i); end
    end else begin
      c = src_pend & src_en & ~src_fast;
      best = -1;
      for (int i = 63; i >= 0; i--)
        if (c[i] && int'(src_pri[4*i +: 4]) > best) begin
          best = int'(src_pri[4*i +: 4]);
          e.word = (32'(i) << 16) | 32'(best);
          e.clr = 1'b1; e.idx = 6'(i);
        end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_fast = fast;
    req_vld  = 1'b1;
    @(negedge clk);
    req_vld  = 1'b0;
    cnt = 1;
    while (!rsp_vld && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == LAT, "R9", "response latency", 32'(cnt), 32'(LAT));
    @(negedge clk);
    check(!rsp_vld && !clr_vld, "R9", "single response strobe",
          {30'b0, rsp_vld, clr_vld}, 32'h0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_vld && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "response without request", 32'(rsp_word), 32'h0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_word == e.word, t, "vector word", rsp_word, e.word);
        check(clr_vld == e.clr, e.clr ? "R8" : t, "clear strobe",
              32'(clr_vld), 32'(e.clr));
        if (e.clr)
          check(clr_idx == e.idx, "R8", "clear index", 32'(clr_idx), 32'(e.idx));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_fast = 1'b0;
    clear_src();
    repeat (3) @(negedge clk);
    check(!rsp_vld && !clr_vld, "R10", "strobes in reset",
          {30'b0, rsp_vld, clr_vld}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // empty
    do_read(1'b0, "R5");
    do_read(1'b1, "R7");

    // field mapping and word format
    clear_src(); src_pend[13] = 1; src_en[13] = 1; set_pri(13, 4'hA);
    check(src_pri[32*1 + 4*5 +: 4] == 4'hA, "R1", "bench nibble map",
          32'(src_pri[52 +: 4]), 32'hA);
    do_read(1'b0, "R1");
    clear_src(); src_pend[63] = 1; src_en[63] = 1; set_pri(63, 4'hF);
    do_read(1'b0, "R4");
    clear_src(); src_pend[8] = 1; src_en[8] = 1; src_pri[32 +: 4] = 4'h3;
    do_read(1'b0, "R1");

    // selection with exclusions
    clear_src();
    src_pend[5] = 1; src_pend[20] = 1; src_pend[40] = 1; src_pend[50] = 1; src_pend[60] = 1;
    src_en = '1; src_en[60] = 0; src_fast[50] = 1;
    set_pri(5, 2); set_pri(20, 9); set_pri(40, 4); set_pri(50, 15); set_pri(60, 15);
    do_read(1'b0, "R2");
    do_read(1'b1, "R6");

    // ties
    clear_src(); src_en = '1;
    src_pend[3] = 1; src_pend[17] = 1; src_pend[45] = 1;
    set_pri(3, 7); set_pri(17, 7); set_pri(45, 7); set_pri(10, 7);
    do_read(1'b0, "R3");
    clear_src(); src_en = '1; src_pend[0] = 1; src_pend[1] = 1;
    do_read(1'b0, "R3");

    // fast path ignores priority, lowest wins
    clear_src(); src_en = '1; src_en[2] = 0;
    src_fast[2] = 1; src_fast[9] = 1; src_fast[30] = 1; src_fast[55] = 1;
    src_pend[2] = 1; src_pend[9] = 1; src_pend[30] = 1; src_pend[55] = 1;
    set_pri(55, 15); set_pri(9, 0);
    do_read(1'b1, "R6");
    do_read(1'b0, "R5");

    // normal candidates only, fast read empty
    clear_src(); src_en = '1; src_pend[12] = 1; set_pri(12, 6);
    do_read(1'b1, "R7");

    // random mix
    for (int k = 0; k < 60; k++) begin
      src_pend = {$urandom, $urandom} & {$urandom, $urandom};
      src_en   = {$urandom, $urandom} | {$urandom, $urandom};
      src_fast = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      for (int w = 0; w < 8; w++) src_pri[32*w +: 32] = $urandom;
      do_read(k[0], k[0] ? "R6" : "R2");
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "responses outstanding",
          32'(exp_q.size()), 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule